// File: doc/BRIEF.md
# Stopwatch run, mode and lap controller

This block is the sequencing core of a runner's stopwatch. It watches four debounced, active-low push-button levels (start/stop, mode, lap/load and a user clear) and turns each falling edge into a single-cycle request. From those requests it steers an external time counter through a count enable, a count direction, a clear strobe and a load strobe. It also drives a display-freeze flag and an index into an external table of preset times.

Two modes exist. In stopwatch (clock) mode the counter runs upward, and the lap button alternately freezes and releases the displayed value while the count keeps running. In countdown (timer) mode the counter runs downward and stops by itself at zero. In this mode the lap button, pressed while stopped, loads the next preset and steps the table index. The mode can be changed only while counting is stopped. Every output is a plain control pin; no data stream crosses the block's edge.

Top module: `swc_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it: mode is clock (`timer_mode`=0), `cnt_en`=0, `cnt_clr`=1, `lap_hold`=0, `cnt_load`=0, `preset_idx`=0; `cnt_clr` drops one cycle after reset is released.
- R2: Each start press toggles counting: `cnt_en` changes on the clock edge that samples the falling edge of `start_n`.
- R3: A clear press forces clock mode, stops counting, releases the lap hold, sets `preset_idx` to 0 and raises `cnt_clr` for exactly the following cycle.
- R4: A mode press toggles `timer_mode` only while stopped; while counting it has no effect.
- R5: `cnt_up` is 1 in clock mode and 0 in timer mode.
- R6: In clock mode each lap press toggles `lap_hold` without changing `cnt_en`.
- R7: Any change of mode drops `lap_hold` to 0; it is never 1 in timer mode.
- R8: In timer mode a lap press while stopped raises `cnt_load` for one cycle, starting one cycle after the press edge. `preset_idx` holds the index to be loaded during that cycle and advances by one on the next edge, wrapping from PRESET_DEPTH-1 (63 by default) to 0.
- R9: In timer mode a lap press while counting has no effect on `cnt_load` or `preset_idx`.
- R10: In timer mode `cnt_en` is 0 whenever `time_zero` is 1. Counting then ends on the next edge, and a start press while `time_zero` is 1 does not start it. In clock mode `time_zero` is ignored.
- R11: Buttons act only on a high-to-low transition of their level. Holding a button low or releasing it causes no further action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Debounced start/stop button level, low when pressed |
| mode_n | input | 1 | Debounced mode button level, low when pressed |
| lap_n | input | 1 | Debounced lap/load button level, low when pressed |
| clr_n | input | 1 | Debounced clear button level, low when pressed |
| time_zero | input | 1 | High when the time counter holds 0:00:00 |
| cnt_en | output | 1 | Count enable for the time counter |
| cnt_up | output | 1 | Count direction, 1 = up |
| cnt_clr | output | 1 | Clear strobe for the time counter |
| cnt_load | output | 1 | Load strobe: counter takes the preset at `preset_idx` |
| lap_hold | output | 1 | Freeze the displayed time while counting continues |
| timer_mode | output | 1 | 1 = timer mode, 0 = clock mode |
| preset_idx | output | 6 | Preset table index (width derived from PRESET_DEPTH) |

## Verification
The embedded assertions check on every cycle that edge requests last one cycle and that a load strobe is followed by a one-step index advance. They also check that a mode request while counting leaves the mode alone, that a mode change drops the hold, that a clear yields a clear strobe with counting stopped, and that counting ends after zero is reached in timer mode. Only the bench's scenarios can show the longer behaviours: holding a button low acts once, the index wraps after a full round of loads, and a start refused at zero stays refused after zero clears. They also show that lap presses alternate the hold across a run.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic {
    MODE_CLOCK = 1'b0,
    MODE_TIMER = 1'b1
  } swc_mode_e;

  localparam int NUM_BTN   = 4;
  localparam int BTN_START = 0;
  localparam int BTN_MODE  = 1;
  localparam int BTN_LAP   = 2;
  localparam int BTN_CLR   = 3;
endpackage

// File: rtl/swc_edge_bank.sv
module swc_edge_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_btn
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= lvl_n[i];
    end

    assign fall[i] = prev_q[i] & ~lvl_n[i];

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> !fall[i]);
  end
endmodule

// File: rtl/swc_run_fsm.sv
module swc_run_fsm
  import swc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_p,
  input  logic      mode_p,
  input  logic      clr_p,
  input  logic      time_zero,
  output logic      running,
  output swc_mode_e mode,
  output logic      cnt_en,
  output logic      cnt_clr
);
  logic at_zero;
  assign at_zero = (mode == MODE_TIMER) && time_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      mode    <= MODE_CLOCK;
      cnt_clr <= 1'b1;
    end else begin
      cnt_clr <= clr_p;
      if (clr_p) begin
        running <= 1'b0;
        mode    <= MODE_CLOCK;
      end else begin
        if (start_p) begin
          if (running)       running <= 1'b0;
          else if (!at_zero) running <= 1'b1;
        end else if (running && at_zero) begin
          running <= 1'b0;
        end
        if (mode_p && !running)
          mode <= (mode == MODE_CLOCK) ? MODE_TIMER : MODE_CLOCK;
      end
    end
  end

  assign cnt_en = running & ~at_zero;

  // R4
  mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_p && running && !clr_p) |=> $stable(mode));
  // R3
  clear_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_p |=> (cnt_clr && !running && mode == MODE_CLOCK));
  // R10
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MODE_TIMER && time_zero && !clr_p) |=> !running);
endmodule

// File: rtl/swc_lap_ctl.sv
module swc_lap_ctl
  import swc_pkg::*;
#(
  parameter int PRESET_DEPTH = 64,
  localparam int IDX_W = $clog2(PRESET_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lap_p,
  input  logic             mode_p,
  input  logic             clr_p,
  input  logic             running,
  input  swc_mode_e        mode,
  output logic             lap_hold,
  output logic             cnt_load,
  output logic [IDX_W-1:0] preset_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PRESET_DEPTH - 1);

  logic mode_flip;
  assign mode_flip = mode_p && !running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lap_hold   <= 1'b0;
      cnt_load   <= 1'b0;
      preset_idx <= '0;
    end else if (clr_p) begin
      lap_hold   <= 1'b0;
      cnt_load   <= 1'b0;
      preset_idx <= '0;
    end else begin
      cnt_load <= lap_p && (mode == MODE_TIMER) && !running;
      if (cnt_load)
        preset_idx <= (preset_idx == LAST_IDX) ? '0 : preset_idx + IDX_W'(1);
      if (mode_flip)
        lap_hold <= 1'b0;
      else if (lap_p && mode == MODE_CLOCK)
        lap_hold <= ~lap_hold;
    end
  end

  // R8
  load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !cnt_load);
  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load && !clr_p && preset_idx != LAST_IDX) |=> (preset_idx == $past(preset_idx) + IDX_W'(1)));
  // R9
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lap_p && running && mode == MODE_TIMER) |=> !cnt_load);
  // R7
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode) || mode == MODE_TIMER) |-> !lap_hold);
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
#(
  parameter int PRESET_DEPTH = 64,
  localparam int IDX_W = $clog2(PRESET_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             mode_n,
  input  logic             lap_n,
  input  logic             clr_n,
  input  logic             time_zero,
  output logic             cnt_en,
  output logic             cnt_up,
  output logic             cnt_clr,
  output logic             cnt_load,
  output logic             lap_hold,
  output logic             timer_mode,
  output logic [IDX_W-1:0] preset_idx
);
  logic [NUM_BTN-1:0] lvl_n;
  logic [NUM_BTN-1:0] fall;
  logic               running;
  swc_mode_e          mode;

  assign lvl_n[BTN_START] = start_n;
  assign lvl_n[BTN_MODE]  = mode_n;
  assign lvl_n[BTN_LAP]   = lap_n;
  assign lvl_n[BTN_CLR]   = clr_n;

  swc_edge_bank #(.N(NUM_BTN)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_n (lvl_n),
    .fall  (fall)
  );

  swc_run_fsm u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_p   (fall[BTN_START]),
    .mode_p    (fall[BTN_MODE]),
    .clr_p     (fall[BTN_CLR]),
    .time_zero (time_zero),
    .running   (running),
    .mode      (mode),
    .cnt_en    (cnt_en),
    .cnt_clr   (cnt_clr)
  );

  swc_lap_ctl #(.PRESET_DEPTH(PRESET_DEPTH)) u_lap (
    .clk        (clk),
    .rst_n      (rst_n),
    .lap_p      (fall[BTN_LAP]),
    .mode_p     (fall[BTN_MODE]),
    .clr_p      (fall[BTN_CLR]),
    .running    (running),
    .mode       (mode),
    .lap_hold   (lap_hold),
    .cnt_load   (cnt_load),
    .preset_idx (preset_idx)
  );

  assign timer_mode = (mode == MODE_TIMER);
  assign cnt_up     = (mode == MODE_CLOCK);

  // R2
  start_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[BTN_START] && running && !fall[BTN_CLR]) |=> !cnt_en);
endmodule

// File: tb/tb_swc_ctrl.sv
module tb_swc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1, mode_n = 1'b1, lap_n = 1'b1, clr_n = 1'b1;
  logic time_zero = 1'b0;
  logic cnt_en, cnt_up, cnt_clr, cnt_load, lap_hold, timer_mode;
  logic [5:0] preset_idx;

  int checks = 0;
  int errors = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  swc_ctrl #(.PRESET_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .mode_n(mode_n),
    .lap_n(lap_n), .clr_n(clr_n), .time_zero(time_zero),
    .cnt_en(cnt_en), .cnt_up(cnt_up), .cnt_clr(cnt_clr), .cnt_load(cnt_load),
    .lap_hold(lap_hold), .timer_mode(timer_mode), .preset_idx(preset_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit m_run, m_timer, m_hold, m_load, m_clr;
  int m_idx;
  bit was_s, was_m, was_l, was_c;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_timer = 0; m_hold = 0; m_load = 0; m_clr = 1; m_idx = 0;
      was_s = 1; was_m = 1; was_l = 1; was_c = 1;
    end else begin
      bit ps, pm, pl, pc, old_run, old_timer;
      ps = was_s && !start_n; pm = was_m && !mode_n;
      pl = was_l && !lap_n;   pc = was_c && !clr_n;
      was_s = start_n; was_m = mode_n; was_l = lap_n; was_c = clr_n;
      old_run = m_run; old_timer = m_timer;
      m_clr = pc;
      if (pc) begin
        m_run = 0; m_timer = 0; m_hold = 0; m_load = 0; m_idx = 0;
      end else begin
        if (m_load) m_idx = (m_idx + 1) % DEPTH;
        m_load = pl && old_timer && !old_run;
        if (ps) m_run = old_run ? 0 : !(old_timer && time_zero);
        else if (old_run && old_timer && time_zero) m_run = 0;
        if (pm && !old_run) begin
          m_timer = !old_timer;
          m_hold = 0;
        end else if (pl && !old_timer) m_hold = !m_hold;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && rst_n && !done) begin
      check("R2", "cnt_en", cnt_en, int'(m_run && !(m_timer && time_zero)));
      check("R4", "timer_mode", timer_mode, m_timer);
      check("R5", "cnt_up", cnt_up, !m_timer);
      check("R6", "lap_hold", lap_hold, m_hold);
      check("R8", "cnt_load", cnt_load, m_load);
      check("R8", "preset_idx", preset_idx, m_idx);
      check("R3", "cnt_clr", cnt_clr, m_clr);
    end
  end

  task automatic drive(int b, logic v);
    case (b)
      0: start_n = v;
      1: mode_n = v;
      2: lap_n = v;
      default: clr_n = v;
    endcase
  endtask

  task automatic press(int b, int hold_cyc);
    @(posedge clk); #(CLK_PERIOD/4);
    drive(b, 1'b0);
    repeat (hold_cyc) @(posedge clk);
    #(CLK_PERIOD/4);
    drive(b, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_zero(logic v);
    @(posedge clk); #(CLK_PERIOD/4);
    time_zero = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "cnt_clr", cnt_clr, 1);
    check("R1", "cnt_en", cnt_en, 0);
    check("R1", "timer_mode", timer_mode, 0);
    check("R1", "idx/hold/load", {preset_idx, lap_hold, cnt_load}, 0);
    @(posedge clk); #(CLK_PERIOD/4); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cnt_clr after release", cnt_clr, 1);
    @(negedge clk);
    check("R1", "cnt_clr drop", cnt_clr, 0);
    compare_on = 1'b1;

    // R11 long hold acts once
    press(0, 5);
    check("R11", "cnt_en after long hold", cnt_en, 1);
    check("R5", "cnt_up clock", cnt_up, 1);
    // R4 mode ignored while counting
    press(1, 1);
    check("R4", "mode while running", timer_mode, 0);
    // R6 lap toggles hold, count continues
    press(2, 1);
    check("R6", "hold on", lap_hold, 1);
    check("R6", "still counting", cnt_en, 1);
    press(2, 1);
    check("R6", "hold off", lap_hold, 0);
    press(2, 1);
    // R10 clock mode ignores zero
    set_zero(1'b1);
    check("R10", "clock ignores zero", cnt_en, 1);
    set_zero(1'b0);
    press(0, 1);
    check("R2", "stopped", cnt_en, 0);
    // R7 mode change drops hold
    check("R7", "hold before change", lap_hold, 1);
    press(1, 1);
    check("R7", "hold after change", lap_hold, 0);
    check("R5", "cnt_up timer", cnt_up, 0);
    // R8 single load
    press(2, 1);
    check("R8", "idx after load", preset_idx, 1);
    // R9 lap while running ignored
    press(0, 1);
    press(2, 1);
    check("R9", "idx unchanged", preset_idx, 1);
    check("R9", "no load", cnt_load, 0);
    // R10 auto stop and refused start
    set_zero(1'b1);
    check("R10", "en low at zero", cnt_en, 0);
    set_zero(1'b0);
    check("R10", "stays stopped", cnt_en, 0);
    set_zero(1'b1);
    press(0, 1);
    set_zero(1'b0);
    check("R10", "start refused at zero", cnt_en, 0);
    // R8 wrap
    for (int i = 0; i < 62; i++) press(2, 1);
    check("R8", "idx at last", preset_idx, 63);
    press(2, 1);
    check("R8", "idx wrapped", preset_idx, 0);
    press(2, 1);
    press(2, 1);
    // R3 clear
    press(3, 1);
    check("R3", "clock mode after clear", timer_mode, 0);
    check("R3", "idx after clear", preset_idx, 0);
    press(0, 1);
    check("R2", "restart", cnt_en, 1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule